// File: doc/BRIEF.md
# ECC Memory Write Path with Disable Mode

This block sits between a requester and a memory array that holds 72 bits per word: 64 data bits and one check byte. Requests carry an address, a 64-bit data word, eight byte enables and a read/write flag. A ready/valid handshake controls them. On every write the block computes the check byte with a SEC-DED Hamming code. On every read it can correct single-bit errors and detect double-bit errors.

The `eccEn` input selects the mode. It is sampled when a request is accepted.

- **Mode enabled.** A write that does not set every byte enable becomes a read-modify-write. The block reads the stored word, corrects it, merges in the new bytes and writes back the full word with a fresh check byte. The requester is held off for the one extra cycle this takes.
- **Mode disabled.** A partial write goes out at once with a memory lane mask. Its check byte is computed as if the unwritten bytes were zero. Reads return the stored data unchecked.

The memory port is synchronous. Read data is expected one cycle after the read is issued.

Top module: `ecc_mem_path`

## Requirements
- R1: The check byte is built as follows. Data bit i takes the (i+1)-th codeword position in 1..71 that is not a power of two. Check bit k (k = 0..6) is the XOR of the data bits whose position has bit k set. Bit 7 is the XOR of all 64 data bits and all 7 check bits. The word stored is {check byte, data}.
- R2: A write with all eight byte enables set is performed in its acceptance cycle in either mode. The memory lane mask `memBe` is all ones, the stored word is the encoded request data, and no read is issued.
- R3: With the mode enabled, a partial write issues a read in its acceptance cycle and a write to the same address in the next cycle. During that second cycle `reqReady` is low. The written word takes enabled bytes from the request and the other bytes from the corrected stored data. It carries a fresh check byte and uses lane mask all ones.
- R4: With the mode disabled, a partial write is a single write in the acceptance cycle. Its lane mask is {1, reqBe}, where lane 8 is the check byte. The check byte is encoded from the request data with unwritten bytes forced to zero. The unwritten data bytes in memory keep their old values.
- R5: A read is issued in its acceptance cycle. `rspValid` is high for exactly the next cycle, and `reqReady` is low in that cycle.
- R6: With the mode enabled, a read of a clean word returns its data with both error flags low.
- R7: With the mode enabled, a single flipped bit anywhere in the 72 bits is corrected in `rspData` and raises `rspCorr`.
- R8: With the mode enabled, two flipped bits raise `rspUncorr`, leave `rspCorr` low and return the stored data bits unchanged.
- R9: With the mode disabled, a read returns the stored 64 data bits as they are, and both flags stay low whatever the check byte holds.
- R10: After reset, `reqReady` is high and `rspValid`, `memEn` and both flags are low while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| eccEn | input | 1 | Check mode, sampled on acceptance |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | AW | Word address |
| reqData | input | 64 | Write data |
| reqBe | input | 8 | Byte enables, bit i covers data bits 8i+7..8i |
| rspValid | output | 1 | Read data valid |
| rspData | output | 64 | Read data |
| rspCorr | output | 1 | Single-bit error corrected |
| rspUncorr | output | 1 | Uncorrectable error seen |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write when high, read when low |
| memAddr | output | AW | Memory word address |
| memBe | output | 9 | Lane mask: lanes 0..7 data bytes, lane 8 check byte |
| memWdata | output | 72 | {check byte, data} to memory |
| memRdata | input | 72 | Word from memory, one cycle after a read |

## Verification
Each result is due at a fixed time after a request is accepted:

| Request | Result and when it is due |
|---|---|
| Read | Response one cycle after acceptance |
| Full write | Memory write in the acceptance cycle |
| Disabled-mode partial write | Memory write in the acceptance cycle |
| Enabled-mode partial write | Read in the acceptance cycle, merged write in the following cycle |

The bench drives requests on the falling edge. At every following falling edge it compares `reqReady` and `rspValid` with the cycle its own model predicts, and it compares data and flags in the response cycle. After each operation the stored memory word is checked against a reference memory kept with an independently written encoder and decoder. Injected bit flips take effect only between operations.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W   = 64;
  localparam int BYTES    = DATA_W / 8;
  localparam int CHK_W    = 7;
  localparam int ECC_W    = CHK_W + 1;
  localparam int WORD_W   = DATA_W + ECC_W;
  localparam int CODE_LEN = DATA_W + CHK_W;

  typedef struct packed {
    logic capture;   // latch request fields and mode
    logic rdIssue;   // memory read for a read or an RMW
    logic wrDirect;  // memory write straight from the request
    logic wrMerge;   // memory write of the merged RMW word
    logic rspFire;   // response cycle of a read
  } ctlStrobes_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              corrected;
    logic              uncorrectable;
  } decodeRes_t;

  function automatic logic isPow2(int v);
    return (v & (v - 1)) == 0;
  endfunction

  function automatic logic [CHK_W-1:0] hamChecks(logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    int p;
    c = '0;
    p = 0;
    for (int pos = 1; pos <= CODE_LEN; pos++) begin
      if (!isPow2(pos)) begin
        for (int k = 0; k < CHK_W; k++)
          if (pos[k]) c[k] = c[k] ^ d[p];
        p++;
      end
    end
    return c;
  endfunction

  function automatic logic [ECC_W-1:0] eccGen(logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = hamChecks(d);
    return {^{d, c}, c};
  endfunction

  function automatic decodeRes_t eccDecode(logic [WORD_W-1:0] w);
    decodeRes_t r;
    logic [CHK_W-1:0] syn;
    logic par;
    int p;
    r.data = w[DATA_W-1:0];
    r.corrected = 1'b0;
    r.uncorrectable = 1'b0;
    syn = hamChecks(w[DATA_W-1:0]) ^ w[DATA_W +: CHK_W];
    par = ^w;
    p = 0;
    if (par) begin
      if (int'(syn) > CODE_LEN) begin
        r.uncorrectable = 1'b1;
      end else begin
        r.corrected = 1'b1;
        for (int pos = 1; pos <= CODE_LEN; pos++) begin
          if (!isPow2(pos)) begin
            if (pos == int'(syn)) r.data[p] = ~r.data[p];
            p++;
          end
        end
      end
    end else if (syn != '0) begin
      r.uncorrectable = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
  import ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             eccEn,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [BYTES-1:0] reqBe,
  output logic             reqReady,
  output logic             rspValid,
  output logic             memEn,
  output logic             memWe,
  output ctlStrobes_t      strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_RDRSP, ST_MERGE} ctlState_t;
  ctlState_t state, stateNext;

  logic accept, fullWord;

  assign fullWord = &reqBe;
  assign accept   = (state == ST_IDLE) && reqValid;

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        strb.capture = accept;
        if (accept) begin
          if (!reqWrite) begin
            strb.rdIssue = 1'b1;
            stateNext    = ST_RDRSP;
          end else if (fullWord || !eccEn) begin
            strb.wrDirect = 1'b1;
          end else begin
            strb.rdIssue = 1'b1;
            stateNext    = ST_MERGE;
          end
        end
      end
      ST_RDRSP: begin
        strb.rspFire = 1'b1;
        stateNext    = ST_IDLE;
      end
      ST_MERGE: begin
        strb.wrMerge = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = strb.rspFire;
  assign memEn    = strb.rdIssue | strb.wrDirect | strb.wrMerge;
  assign memWe    = strb.wrDirect | strb.wrMerge;
endmodule

// File: rtl/ecc_datapath.sv
module ecc_datapath
  import ecc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic              eccEn,
  input  logic [AW-1:0]     reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [BYTES-1:0]  reqBe,
  input  logic [WORD_W-1:0] memRdata,
  output logic [AW-1:0]     memAddr,
  output logic [BYTES:0]    memBe,
  output logic [WORD_W-1:0] memWdata,
  output logic [DATA_W-1:0] rspData,
  output logic              rspCorr,
  output logic              rspUncorr
);
  logic [AW-1:0]     latAddr;
  logic [DATA_W-1:0] latData;
  logic [BYTES-1:0]  latBe;
  logic              latMode;
  logic [DATA_W-1:0] reqMask, latMask, directWord, mergedWord;
  decodeRes_t        dec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr <= '0;
      latData <= '0;
      latBe   <= '0;
      latMode <= 1'b0;
    end else if (strb.capture) begin
      latAddr <= reqAddr;
      latData <= reqData;
      latBe   <= reqBe;
      latMode <= eccEn;
    end
  end

  for (genvar b = 0; b < BYTES; b++) begin : gLane
    assign reqMask[8*b +: 8] = {8{reqBe[b]}};
    assign latMask[8*b +: 8] = {8{latBe[b]}};
  end

  assign dec        = eccDecode(memRdata);
  assign directWord = reqData & reqMask;
  assign mergedWord = (latData & latMask) | (dec.data & ~latMask);

  always_comb begin
    if (strb.wrMerge) begin
      memAddr  = latAddr;
      memBe    = '1;
      memWdata = {eccGen(mergedWord), mergedWord};
    end else begin
      memAddr  = reqAddr;
      memBe    = {1'b1, reqBe};
      memWdata = {eccGen(directWord), directWord};
    end
  end

  assign rspData   = latMode ? dec.data : memRdata[DATA_W-1:0];
  assign rspCorr   = strb.rspFire & latMode & dec.corrected;
  assign rspUncorr = strb.rspFire & latMode & dec.uncorrectable;
endmodule

// File: rtl/ecc_mem_path.sv
module ecc_mem_path
  import ecc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eccEn,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [AW-1:0]     reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [BYTES-1:0]  reqBe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspCorr,
  output logic              rspUncorr,
  output logic              memEn,
  output logic              memWe,
  output logic [AW-1:0]     memAddr,
  output logic [BYTES:0]    memBe,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata
);
  ctlStrobes_t strb;

  ecc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .eccEn(eccEn), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqBe(reqBe), .reqReady(reqReady),
    .rspValid(rspValid), .memEn(memEn), .memWe(memWe), .strb(strb)
  );

  ecc_datapath #(.AW(AW)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .eccEn(eccEn),
    .reqAddr(reqAddr), .reqData(reqData), .reqBe(reqBe),
    .memRdata(memRdata), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .rspData(rspData), .rspCorr(rspCorr),
    .rspUncorr(rspUncorr)
  );
endmodule

// File: rtl/ecc_mem_path_chk.sv
module ecc_mem_path_chk
  import ecc_pkg::*;
#(
  parameter int AW = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              eccEn,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic [AW-1:0]     reqAddr,
  input logic [BYTES-1:0]  reqBe,
  input logic              rspValid,
  input logic              rspCorr,
  input logic              rspUncorr,
  input logic              memEn,
  input logic              memWe,
  input logic [AW-1:0]     memAddr,
  input logic [BYTES:0]    memBe
);
  logic acc;
  assign acc = reqValid && reqReady;

  assert_full_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    acc && reqWrite && (&reqBe) |-> memEn && memWe && (&memBe));

  assert_rmw_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    acc && reqWrite && eccEn && !(&reqBe) |-> memEn && !memWe);

  assert_rmw_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    acc && reqWrite && eccEn && !(&reqBe) |=>
      memEn && memWe && (&memBe) && !reqReady && memAddr == $past(reqAddr));

  assert_plain_partial_R4: assert property (@(posedge clk) disable iff (!rstN)
    acc && reqWrite && !eccEn |-> memEn && memWe && memBe == {1'b1, reqBe});

  assert_read_issue_R5: assert property (@(posedge clk) disable iff (!rstN)
    acc && !reqWrite |-> memEn && !memWe);

  assert_read_resp_R5: assert property (@(posedge clk) disable iff (!rstN)
    acc && !reqWrite |=> rspValid && !reqReady);

  assert_resp_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid && reqReady);

  assert_flag_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rspCorr || rspUncorr) |-> rspValid);

  assert_flag_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(rspCorr && rspUncorr));
endmodule

bind ecc_mem_path ecc_mem_path_chk #(.AW(AW)) uChk (.*);

// File: tb/sim_ecc_mem_path.sv
`timescale 1ns/1ps
module sim_ecc_mem_path;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rstN = 1'b0;
  logic eccEn = 1'b1, reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [63:0] reqData = '0;
  logic [7:0] reqBe = '0;
  logic reqReady, rspValid, rspCorr, rspUncorr, memEn, memWe;
  logic [63:0] rspData;
  logic [AW-1:0] memAddr;
  logic [8:0] memBe;
  logic [71:0] memWdata;
  logic [71:0] memRdata = '0;

  logic [71:0] mem [DEPTH];
  logic [71:0] refMem [DEPTH];
  logic injEn = 1'b0;
  logic [AW-1:0] injAddr = '0;
  logic [71:0] injMask = '0;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ecc_mem_path #(.AW(AW)) u0 (.*);

  initial for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  always @(posedge clk) begin
    if (injEn) mem[injAddr] <= mem[injAddr] ^ injMask;
    else if (memEn && memWe) begin
      for (int l = 0; l < 9; l++)
        if (memBe[l]) mem[memAddr][8*l +: 8] <= memWdata[8*l +: 8];
    end else if (memEn) memRdata <= mem[memAddr];
  end

  // Reference code: positions 1..71, data in non-power-of-two slots.
  function automatic logic [7:0] refEcc(logic [63:0] d);
    logic cw [72];
    logic [7:0] c;
    int di;
    di = 0;
    c = '0;
    for (int pos = 1; pos < 72; pos++) begin
      if ((pos & (pos - 1)) != 0) begin cw[pos] = d[di]; di++; end
      else cw[pos] = 1'b0;
    end
    for (int k = 0; k < 7; k++)
      for (int pos = 1; pos < 72; pos++)
        if (((pos >> k) & 1) == 1) c[k] = c[k] ^ cw[pos];
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  task automatic refDecode(input logic [71:0] w, output logic [63:0] d,
                           output logic corr, output logic unc);
    logic [6:0] s;
    int di, syn;
    s = refEcc(w[63:0])[6:0] ^ w[70:64];
    syn = int'(s);
    d = w[63:0];
    corr = 1'b0;
    unc = 1'b0;
    if (^w) begin
      if (syn > 71) unc = 1'b1;
      else begin
        corr = 1'b1;
        di = 0;
        for (int pos = 1; pos < 72; pos++)
          if ((pos & (pos - 1)) != 0) begin
            if (pos == syn) d[di] = ~d[di];
            di++;
          end
      end
    end else if (syn != 0) unc = 1'b1;
  endtask

  function automatic logic [63:0] bmask(logic [7:0] be);
    logic [63:0] m;
    for (int b = 0; b < 8; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [71:0] act,
                     input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [71:0] m);
    injAddr = a; injMask = m; injEn = 1'b1;
    @(posedge clk); @(negedge clk);
    injEn = 1'b0;
    refMem[a] = refMem[a] ^ m;
  endtask

  task automatic doOp(input bit wr, input logic [AW-1:0] a, input logic [63:0] d,
                      input logic [7:0] be, input bit mode, input string tag);
    logic [63:0] ed, dd, merged, zf;
    logic ec, eu;
    bit rmw;
    refDecode(refMem[a], ed, ec, eu);
    if (!mode) begin ed = refMem[a][63:0]; ec = 1'b0; eu = 1'b0; end
    rmw = wr && mode && (be != 8'hFF);
    eccEn = mode; reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqData = d; reqBe = be;
    chk(reqReady == 1'b1, {tag, " ready before accept"}, 72'(reqReady), 72'(1));
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    if (!wr) begin
      chk(rspValid == 1'b1 && reqReady == 1'b0, {tag, " R5 response cycle"},
          72'({rspValid, reqReady}), 72'(2'b10));
      chk(rspData == ed, {tag, " read data"}, 72'(rspData), 72'(ed));
      chk(rspCorr == ec && rspUncorr == eu, {tag, " flags"},
          72'({rspCorr, rspUncorr}), 72'({ec, eu}));
      @(posedge clk); @(negedge clk);
      chk(rspValid == 1'b0 && reqReady == 1'b1, {tag, " R5 single pulse"},
          72'({rspValid, reqReady}), 72'(2'b01));
    end else begin
      if (rmw) begin
        chk(reqReady == 1'b0 && rspValid == 1'b0, {tag, " R3 hold cycle"},
            72'({rspValid, reqReady}), 72'(0));
        @(posedge clk); @(negedge clk);
        refDecode(refMem[a], dd, ec, eu);
        merged = (d & bmask(be)) | (dd & ~bmask(be));
        refMem[a] = {refEcc(merged), merged};
      end else if (be == 8'hFF) begin
        refMem[a] = {refEcc(d), d};
      end else begin
        zf = d & bmask(be);
        refMem[a] = {refEcc(zf), (zf | (refMem[a][63:0] & ~bmask(be)))};
      end
      chk(reqReady == 1'b1 && rspValid == 1'b0, {tag, " idle after write"},
          72'({rspValid, reqReady}), 72'(1));
      chk(mem[a] == refMem[a], {tag, " stored word"}, mem[a], refMem[a]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !rspValid && !memEn && !rspCorr && !rspUncorr, "R10 reset state",
        72'({reqReady, rspValid, memEn, rspCorr, rspUncorr}), 72'(5'b10000));

    // R1/R2: full writes, encoding checked through the stored word
    doOp(1, 1, 64'h0123_4567_89AB_CDEF, 8'hFF, 1, "R1 R2 full write on");
    doOp(1, 2, 64'hFFFF_0000_A5A5_5A5A, 8'hFF, 0, "R2 full write off");
    doOp(0, 1, '0, '0, 1, "R6 clean read");
    doOp(0, 2, '0, '0, 1, "R6 clean read 2");
    // R3: enabled partial write merges
    doOp(1, 1, 64'hDEAD_BEEF_1122_3344, 8'h0F, 1, "R3 rmw low bytes");
    doOp(0, 1, '0, '0, 1, "R3 readback");
    // R7: single data-bit and check-bit errors
    inject(1, 72'(1) << 10);
    doOp(0, 1, '0, '0, 1, "R7 data bit");
    inject(2, 72'(1) << 66);
    doOp(0, 2, '0, '0, 1, "R7 check bit");
    inject(2, 72'(1) << 71);
    doOp(0, 2, '0, '0, 1, "R8 double error");
    // R9: disabled read ignores corruption
    doOp(0, 1, '0, '0, 0, "R9 raw read");
    // R3: merge over a corrupted word uses corrected data
    doOp(1, 1, 64'h0000_0000_0000_0077, 8'h01, 1, "R3 rmw over error");
    doOp(0, 1, '0, '0, 1, "R3 readback corrected");
    // R4: disabled partial write, zero-filled check byte
    doOp(1, 3, 64'hCAFE_F00D_0BAD_BEEF, 8'hFF, 1, "R4 setup");
    doOp(1, 3, 64'h1357_9BDF_2468_ACE0, 8'hF0, 0, "R4 plain partial");
    doOp(0, 3, '0, '0, 0, "R4 R9 raw readback");
    doOp(0, 3, '0, '0, 1, "R4 checked readback");

    for (int n = 0; n < 60; n++) begin
      logic [7:0] be;
      be = 8'($urandom);
      if (n % 5 == 0) be = 8'hFF;
      doOp(1'($urandom), AW'($urandom), {$urandom, $urandom}, be, 1'($urandom),
           "R2 R3 R4 R6 mixed");
    end

    for (int i = 0; i < DEPTH; i++)
      chk(mem[i] == refMem[i], "R1 final memory", mem[i], refMem[i]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule